// File: doc/BRIEF.md
# TDM Sixteen-Channel Audio Serial Transmitter

This block turns a bank of sixteen 16-bit audio samples into one serial time-division multiplexed data line. It also produces a frame-sync pulse. It is clocked by the bit clock, which runs at 256 times the frame rate: 11.2896 MHz for 44.1 kHz audio. Each frame is a fixed 256 bit periods long. A layout input selects how the frame is divided. In narrow layout there are sixteen 16-bit slots packed back to back. In wide layout there are eight 32-bit slots, and each slot carries a 16-bit sample at its start.

An upstream producer offers a full bank of samples with a valid/ready handshake. The bank is copied into a shadow store only at the frame boundary. A one-cycle request strobe then tells the producer that the next bank may be prepared. If no bank is offered at a boundary, the next frame is sent as silence and a sticky underrun flag is raised. Serial data and frame sync change on the falling edge of the bit clock, so that downstream converters can sample them on the rising edge. The frame-sync pulse goes high during the last bit of the preceding frame.

Top module: `tdm16_tx`

## Requirements
- R1: A frame is exactly 256 bit-clock periods, and `tdm_fs` is high for exactly one of those periods in every frame.
- R2: The rising clock edge that samples `tdm_fs` high is the one just before the edge that samples the first data bit of the frame; at that edge `tdm_sd` still carries bit 255 of the preceding frame.
- R3: With `layout_sel`=0 at the boundary, frame bits 16i to 16i+15 carry channel i, which is `smp_bank[16i +: 16]`, most significant bit first, for i = 0..15.
- R4: With `layout_sel`=1 at the boundary, frame bits 32j to 32j+15 carry channel j (j = 0..7), most significant bit first, and frame bits 32j+16 to 32j+31 are low; channels 8..15 are not sent.
- R5: `tdm_sd` and `tdm_fs` change only on the falling clock edge, so both hold the same value just before and just after every rising edge.
- R6: `smp_ready` is high for exactly one clock cycle per frame, during the last bit period. The bank is taken only on the rising edge that ends that cycle, and only when `smp_valid` is high; bank and valid values in all other cycles have no effect on any frame.
- R7: `sample_req` is high for exactly the one cycle that follows each frame boundary.
- R8: A boundary with `smp_valid` low makes the next frame all zeros and sets `underrun`, which then stays high until reset.
- R9: `layout_sel` is taken only at the frame boundary; changing it at any other time does not alter the frame in flight.
- R10: During reset, `tdm_sd`, `tdm_fs`, `smp_ready`, `sample_req` and `underrun` are low. The first boundary falls in the second cycle after reset is released, so `tdm_fs` is first sampled high at the second rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 256 times the frame rate |
| rst_n | input | 1 | Synchronous active-low reset |
| layout_sel | input | 1 | 0: sixteen 16-bit slots, 1: eight 32-bit slots |
| smp_valid | input | 1 | A sample bank is offered |
| smp_bank | input | 256 | Sixteen samples, channel i in bits 16i+15..16i |
| smp_ready | output | 1 | High in the last bit period; the bank is taken at its end |
| sample_req | output | 1 | One-cycle strobe after each boundary |
| underrun | output | 1 | Sticky: a boundary passed with no valid bank |
| tdm_sd | output | 1 | Serial data, changes on the falling edge |
| tdm_fs | output | 1 | Frame sync, one bit wide, one bit early |

## Verification
The bench builds the block with its default sizes: sixteen channels of sixteen bits, which gives the full 256-bit frame. Every slot edge is therefore real. This covers the sixteen-bit slot seams, the 32-bit slot seams with their zero padding, and the wrap from bit 255 of one frame into the frame sync of the next. Over about forty frames it varies the layout and the valid signal at each boundary. Between boundaries it drives junk banks, junk layout values and stray valid pulses. This exposes any leak of non-boundary input into a frame that is already being sent.

// File: rtl/tdm16_pkg.sv
`timescale 1ns/1ps
// Shared types for the TDM transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tdm16_pkg;

    // Slot layout chosen at each frame boundary.
    typedef enum logic {
        LAYOUT_NARROW = 1'b0,   // sixteen slots of one sample width
        LAYOUT_WIDE   = 1'b1    // eight slots of twice the sample width
    } layout_e;

endpackage

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
// Bit-position counter for one TDM frame.
// Counts 0..FRAME_BITS-1 on the rising edge and flags the last position.
// Reset parks the counter one position before the last, so that the first
// boundary comes in the second cycle after reset release.
// Assumes FRAME_BITS >= 2.
module tdm_frame_timer #(
    parameter int FRAME_BITS = 256,
    localparam int IW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] bit_idx,
    output logic          at_last
);
    localparam logic [IW-1:0] LAST_POS  = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] RESET_POS = IW'(FRAME_BITS - 2);

    // Advance the bit position, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_idx <= RESET_POS;
        else if (bit_idx == LAST_POS)
            bit_idx <= '0;
        else
            bit_idx <= bit_idx + 1'b1;
    end

    // Flag the final bit period of the frame.
    always_comb at_last = (bit_idx == LAST_POS);

endmodule

// File: rtl/tdm_sample_bank.sv
`timescale 1ns/1ps
// Shadow store for one frame of samples.
// On a boundary it takes the offered bank (or zeros when none is valid),
// captures the layout, raises the request strobe for one cycle and
// records underrun. Assumes load is high for one cycle per frame.
module tdm_sample_bank
    import tdm16_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int SAMPLE_W = 16,
    localparam int BANK_W = CHANNELS * SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bank_valid,
    input  logic [BANK_W-1:0] bank_in,
    input  layout_e           layout_in,
    output logic [BANK_W-1:0] shadow,
    output layout_e           layout_q,
    output logic              req_strobe,
    output logic              underrun_flag
);
    // One shadow register per channel.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        // Latch this channel at the boundary, silence when nothing is valid.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[c*SAMPLE_W +: SAMPLE_W] <= '0;
            else if (load)
                shadow[c*SAMPLE_W +: SAMPLE_W] <= bank_valid ?
                    bank_in[c*SAMPLE_W +: SAMPLE_W] : '0;
        end
    end

    // Capture the layout, the request strobe and the sticky underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q      <= LAYOUT_NARROW;
            req_strobe    <= 1'b0;
            underrun_flag <= 1'b0;
        end else begin
            req_strobe <= load;
            if (load) begin
                layout_q <= layout_in;
                if (!bank_valid)
                    underrun_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_bit_select.sv
`timescale 1ns/1ps
// Picks the frame bit for a given bit position from the shadow store.
// Narrow layout: slot = position / SAMPLE_W, MSB first.
// Wide layout: slot = position / (2*SAMPLE_W); the first half of the slot
// carries the sample MSB first, the second half is low.
// Assumes CHANNELS and SAMPLE_W are powers of two, CHANNELS >= 2.
module tdm_bit_select
    import tdm16_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int SAMPLE_W = 16,
    localparam int BANK_W = CHANNELS * SAMPLE_W,
    localparam int IW     = $clog2(BANK_W),
    localparam int OW     = $clog2(SAMPLE_W)
) (
    input  logic [BANK_W-1:0] shadow,
    input  layout_e           layout_q,
    input  logic [IW-1:0]     bit_idx,
    output logic              bit_o
);
    logic [IW-1:0] narrow_sel;
    logic [IW-1:0] wide_sel;
    logic          wide_pad;

    // Map the bit position to a shadow index in each layout.
    always_comb begin
        narrow_sel = {bit_idx[IW-1:OW], ~bit_idx[OW-1:0]};
        wide_sel   = {1'b0, bit_idx[IW-1:OW+1], ~bit_idx[OW-1:0]};
        wide_pad   = bit_idx[OW];
    end

    // Choose the bit for the active layout.
    always_comb begin
        if (layout_q == LAYOUT_WIDE)
            bit_o = wide_pad ? 1'b0 : shadow[wide_sel];
        else
            bit_o = shadow[narrow_sel];
    end

endmodule

// File: rtl/tdm16_tx.sv
`timescale 1ns/1ps
// TDM audio serial transmitter, top level.
// Core state moves on the rising edge of the bit clock; serial data and
// frame sync are relaunched on the falling edge so that receivers sample
// them on the rising edge. Frame sync is high during the last bit of a
// frame. Assumes clk is the bit clock and rst_n is synchronous to it.
module tdm16_tx
    import tdm16_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int SAMPLE_W = 16,
    localparam int BANK_W = CHANNELS * SAMPLE_W,
    localparam int IW     = $clog2(BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              layout_sel,
    input  logic              smp_valid,
    input  logic [BANK_W-1:0] smp_bank,
    output logic              smp_ready,
    output logic              sample_req,
    output logic              underrun,
    output logic              tdm_sd,
    output logic              tdm_fs
);
    logic [IW-1:0]     bit_idx;
    logic              at_last;
    logic [BANK_W-1:0] shadow;
    layout_e           layout_q;
    logic              bit_nxt;

    tdm_frame_timer #(.FRAME_BITS(BANK_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_idx (bit_idx),
        .at_last (at_last)
    );

    tdm_sample_bank #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (at_last),
        .bank_valid    (smp_valid),
        .bank_in       (smp_bank),
        .layout_in     (layout_e'(layout_sel)),
        .shadow        (shadow),
        .layout_q      (layout_q),
        .req_strobe    (sample_req),
        .underrun_flag (underrun)
    );

    tdm_bit_select #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_sel (
        .shadow   (shadow),
        .layout_q (layout_q),
        .bit_idx  (bit_idx),
        .bit_o    (bit_nxt)
    );

    // The boundary cycle is the one in which a bank is accepted.
    always_comb smp_ready = at_last;

    // Launch data and frame sync on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            tdm_sd <= 1'b0;
            tdm_fs <= 1'b0;
        end else begin
            tdm_sd <= bit_nxt;
            tdm_fs <= at_last;
        end
    end

endmodule

// File: rtl/tdm16_tx_chk.sv
`timescale 1ns/1ps
// Protocol checker for tdm16_tx, attached by bind.
module tdm16_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic smp_ready,
    input logic sample_req,
    input logic underrun,
    input logic tdm_fs
);
    AST_FS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) tdm_fs == smp_ready); // R2
    AST_READY_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) smp_ready |=> !smp_ready); // R6
    AST_REQ_FOLLOWS:    assert property (@(posedge clk) disable iff (!rst_n) smp_ready |=> sample_req); // R7
    AST_REQ_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n) sample_req |-> $past(smp_ready)); // R7
    AST_UNDERRUN_SET:   assert property (@(posedge clk) disable iff (!rst_n) (smp_ready && !smp_valid) |=> underrun); // R8
    AST_UNDERRUN_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun); // R8
endmodule

bind tdm16_tx tdm16_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .sample_req (sample_req),
    .underrun   (underrun),
    .tdm_fs     (tdm_fs)
);

// File: tb/sim_tdm16_tx.sv
`timescale 1ns/1ps
// Bench for tdm16_tx: random and directed banks, layouts and underruns,
// with frames decoded from the serial line and compared to a model.
module sim_tdm16_tx;
    localparam int CH = 16;
    localparam int W  = 16;
    localparam int FB = CH * W;
    localparam int NF = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          layout_sel = 1'b0;
    logic          smp_valid = 1'b0;
    logic [FB-1:0] smp_bank = '0;
    logic          smp_ready, sample_req, underrun, tdm_sd, tdm_fs;

    int n_cmp = 0;
    int n_bad = 0;
    int frames_done = 0;
    logic [FB-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    tdm16_tx #(.CHANNELS(CH), .SAMPLE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .smp_valid(smp_valid),
        .smp_bank(smp_bank), .smp_ready(smp_ready), .sample_req(sample_req),
        .underrun(underrun), .tdm_sd(tdm_sd), .tdm_fs(tdm_fs)
    );

    // Record one check result.
    task automatic check(input string req, input logic ok, input logic [FB-1:0] act,
                         input logic [FB-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Expected serial frame, index k = bit sent in position k.
    function automatic logic [FB-1:0] exp_frame(input logic [FB-1:0] bank, input logic wide);
        logic [FB-1:0] f;
        for (int k = 0; k < FB; k++) begin
            if (!wide) begin
                f[k] = bank[(k / W) * W + (W - 1 - (k % W))];
            end else begin
                int off = k % (2 * W);
                f[k] = (off < W) ? bank[(k / (2 * W)) * W + (W - 1 - off)] : 1'b0;
            end
        end
        return f;
    endfunction

    function automatic logic [FB-1:0] rnd_bank();
        logic [FB-1:0] b;
        for (int i = 0; i < FB / 32; i++) b[i*32 +: 32] = $urandom;
        return b;
    endfunction

    // Driver: choose the bank at each boundary, junk in other cycles.
    logic model_unr = 1'b0;
    int   frame_no = 0;
    initial begin
        void'($urandom(32'h5eed_1234));
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (smp_ready) begin
                logic [FB-1:0] b;
                logic v, wd;
                check("R8 sticky underrun", underrun == model_unr, FB'(underrun), FB'(model_unr));
                case (frame_no)
                    0: begin b = '1; wd = 1'b0; v = 1'b1; end
                    1: begin
                        for (int c = 0; c < CH; c++) b[c*W +: W] = (16'h8000 >> c) | 16'h0001;
                        wd = 1'b0; v = 1'b1;
                    end
                    2: begin b = '1; wd = 1'b1; v = 1'b1; end
                    3: begin b = rnd_bank(); wd = 1'b0; v = 1'b1; end
                    4: begin b = rnd_bank(); wd = 1'b0; v = 1'b0; end
                    5: begin b = rnd_bank(); wd = 1'b1; v = 1'b1; end
                    default: begin
                        b = rnd_bank(); wd = 1'($urandom); v = ($urandom % 8) != 0;
                    end
                endcase
                smp_bank = b; layout_sel = wd; smp_valid = v;
                exp_q.push_back(v ? exp_frame(b, wd) : '0);
                tag_q.push_back(!v ? "R8 R6" : (wd ? "R4 R6 R9" : "R3 R6 R9"));
                if (!v) model_unr = 1'b1;
                frame_no++;
            end else begin
                smp_bank = rnd_bank(); layout_sel = 1'($urandom); smp_valid = 1'($urandom);
            end
        end
    end

    // Monitor: decode frames from the line at rising edge + 2 ns.
    initial begin
        int idx = -1;
        logic [FB-1:0] got = '0;
        logic pre_ok = 1'b0, pre_f = 1'b0, pre_d = 1'b0;
        logic fs_err = 1'b0, req_err = 1'b0, stab_err = 1'b0;
        int   fs_cnt = 0;
        forever begin
            logic f, d;
            @(posedge clk);
            #2;
            f = tdm_fs; d = tdm_sd;
            if (!rst_n) begin
                pre_ok = 1'b0;
            end else begin
                if (pre_ok && (f != pre_f || d != pre_d)) stab_err = 1'b1;
                if (sample_req != f) req_err = 1'b1;
                if (f) fs_cnt++;
                if (idx >= 0) begin
                    got[idx] = d;
                    if (f != (idx == FB - 1)) fs_err = 1'b1;
                    idx++;
                    if (idx == FB) begin
                        logic [FB-1:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, got == e, got, e);
                        check("R1 R2 frame sync placement", !fs_err && fs_cnt == 1,
                              FB'(fs_cnt), FB'(1));
                        check("R7 request strobe", !req_err, FB'(req_err), '0);
                        check("R5 stable across rising edge", !stab_err, FB'(stab_err), '0);
                        fs_err = 1'b0; req_err = 1'b0; stab_err = 1'b0; fs_cnt = 0;
                        frames_done++;
                        idx = 0;
                    end
                end else if (f) begin
                    idx = 0; fs_cnt = 0; req_err = 1'b0; stab_err = 1'b0;
                end
                pre_ok = 1'b1;
            end
            #7;
            pre_f = tdm_fs; pre_d = tdm_sd;
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected %0d frames", NF);
        finish_run();
    end

    // Main sequence: reset checks, release, first sync timing, wait for frames.
    initial begin
        repeat (4) @(posedge clk);
        #2;
        check("R10 reset sd", tdm_sd == 1'b0, FB'(tdm_sd), '0);
        check("R10 reset fs", tdm_fs == 1'b0, FB'(tdm_fs), '0);
        check("R10 reset ready", smp_ready == 1'b0, FB'(smp_ready), '0);
        check("R10 reset req", sample_req == 1'b0, FB'(sample_req), '0);
        check("R10 reset underrun", underrun == 1'b0, FB'(underrun), '0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R10 no sync one edge after release", tdm_fs == 1'b0, FB'(tdm_fs), '0);
        @(posedge clk); #2;
        check("R10 first sync at second edge", tdm_fs == 1'b1, FB'(tdm_fs), FB'(1));
        wait (frames_done >= NF);
        finish_run();
    end

endmodule